// File: doc/BRIEF.md
# CAN Stop-Mode and Self-Wake Controller

This block sequences a CAN protocol controller into and out of its low-power stop state. The host raises a stop request. The block then holds off until the bus is at a safe point: the protocol engine reports idle or bus-off, or the third bit of intermission is sampled recessive. It also waits until the engine's internal work (arbitration, matching, message moves) has drained. Only then does it acknowledge, so the host may gate the clocks. While stopped, the transmit pin is held recessive and the receive path seen by the engine is forced recessive.

If self-wake was enabled at the moment of entry, a falling edge (recessive to dominant) on the raw receive line sets a sticky wake status bit. That bit raises the wake interrupt when both the self-wake enable and the wake interrupt mask are set. The host leaves stop by removing the request. The block then keeps the engine off the bus until it has counted eleven consecutive recessive bits on the bit-time strobe, so the frame that caused the wake-up is skipped.

Top module: `can_stop_ctl`

## Requirements
- R1: After a stop request, entry does not go further until `bus_idle`, `bus_off`, or `intm3_smp` together with `rx_in`=1 (recessive) is seen; an intermission strobe with `rx_in`=0 does not count.
- R2: Once the bus condition is met, entry waits while `busy` is 1. The stop state is entered on the first clock edge where `busy` is 0.
- R3: While stopped and during resynchronisation, `tx_pin` is 1 and `rx_core` is 1 whatever `tx_core` and `rx_in` are. In normal operation they pass `tx_core` and `rx_in` through.
- R4: In the stop state `stop_ack`, `not_rdy` and `lpm_ack` are all 1. They return to 0 on the clock edge that samples `stop_req`=0.
- R5: Self-wake is armed only if `slf_wake_en` was 1 on the edge that entered stop. Setting it later during the same stop does not arm it.
- R6: While stopped and armed, a clock edge where `rx_in` is 0 and the previous sample was 1 sets `wake_flag`.
- R7: `wake_irq` is 1 exactly when `wake_flag`, `slf_wake_en` and `wake_msk` are all 1.
- R8: Sampling `stop_req`=0 in the stop state leaves stop and starts resynchronisation with the count at zero.
- R9: During resynchronisation each `bit_stb` with `rx_in`=1 adds one to the count and a `bit_stb` with `rx_in`=0 clears it. `on_bus` returns to 1 on the edge of the 11th consecutive recessive strobe.
- R10: `wake_flag` stays set until a cycle with `wake_clr`=1. A new wake edge in the same cycle wins over the clear.
- R11: Withdrawing `stop_req` before entry completes returns to normal operation (`on_bus`=1) without `stop_ack` ever rising.
- R12: Under reset `on_bus` is 1, `wake_flag` is 0, and `stop_ack`, `not_rdy` and `lpm_ack` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_req | input | 1 | Host stop request |
| slf_wake_en | input | 1 | Self-wake enable control bit |
| wake_msk | input | 1 | Wake interrupt mask control bit |
| bus_idle | input | 1 | Protocol engine is idle |
| bus_off | input | 1 | Protocol engine is bus-off |
| intm3_smp | input | 1 | Sample point of third intermission bit |
| busy | input | 1 | Internal activity pending |
| bit_stb | input | 1 | Bit-time sample strobe |
| rx_in | input | 1 | Sampled receive line (1 = recessive) |
| tx_core | input | 1 | Transmit bit from protocol engine |
| wake_clr | input | 1 | Write-one-to-clear for the wake status |
| stop_ack | output | 1 | Stop acknowledge to host |
| not_rdy | output | 1 | Not-ready status bit |
| lpm_ack | output | 1 | Low-power acknowledge status bit |
| tx_pin | output | 1 | Transmit pin |
| rx_core | output | 1 | Receive bit delivered to protocol engine |
| wake_flag | output | 1 | Sticky wake status |
| wake_irq | output | 1 | Wake interrupt |
| on_bus | output | 1 | Engine is synchronised and on the bus |

## Verification
The assertions assume that the status inputs are clean levels sampled on `clk`. They also assume that `bit_stb` and `intm3_smp` are single-cycle strobes and that the host holds `stop_req` level for at least one cycle. The stimulus drives every input once per cycle, shortly after the rising edge. It pulses the strobes for one cycle only. It changes the control bits and `rx_in` in the stop state to reach each wake combination: armed and unarmed, masked and unmasked, and a clear that coincides with a wake edge.

// File: rtl/can_stop_ctl.sv
module can_stop_ctl #(
  parameter int RESYNC_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic slf_wake_en,
  input  logic wake_msk,
  input  logic bus_idle,
  input  logic bus_off,
  input  logic intm3_smp,
  input  logic busy,
  input  logic bit_stb,
  input  logic rx_in,
  input  logic tx_core,
  input  logic wake_clr,
  output logic stop_ack,
  output logic not_rdy,
  output logic lpm_ack,
  output logic tx_pin,
  output logic rx_core,
  output logic wake_flag,
  output logic wake_irq,
  output logic on_bus
);

  localparam int CW = $clog2(RESYNC_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(RESYNC_BITS - 1);

  typedef enum logic [2:0] {S_RUN, S_WBUS, S_WDRAIN, S_STOP, S_SYNC} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          armed;
  logic          rx_q;

  wire safe    = bus_idle | bus_off | (intm3_smp & rx_in);
  wire stopped = (st == S_STOP);
  wire muted   = stopped | (st == S_SYNC);
  wire wake_ev = stopped & armed & rx_q & ~rx_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_RUN;
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      unique case (st)
        S_RUN:    if (stop_req) st <= S_WBUS;
        S_WBUS:   if (!stop_req) st <= S_RUN;
                  else if (safe) st <= S_WDRAIN;
        S_WDRAIN: if (!stop_req) st <= S_RUN;
                  else if (!busy) begin
                    st    <= S_STOP;
                    armed <= slf_wake_en;
                  end
        S_STOP:   if (!stop_req) begin
                    st  <= S_SYNC;
                    cnt <= '0;
                  end
        S_SYNC:   if (bit_stb) begin
                    if (!rx_in) cnt <= '0;
                    else if (cnt == LAST) begin
                      cnt <= '0;
                      st  <= S_RUN;
                    end else cnt <= cnt + 1'b1;
                  end
        default:  st <= S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q      <= 1'b1;
      wake_flag <= 1'b0;
    end else begin
      rx_q <= rx_in;
      if (wake_ev) wake_flag <= 1'b1;
      else if (wake_clr) wake_flag <= 1'b0;
    end
  end

  assign stop_ack = stopped;
  assign not_rdy  = stopped;
  assign lpm_ack  = stopped;
  assign tx_pin   = muted | tx_core;
  assign rx_core  = muted | rx_in;
  assign wake_irq = wake_flag & slf_wake_en & wake_msk;
  assign on_bus   = (st == S_RUN);

endmodule

// File: rtl/can_stop_ctl_chk.sv
module can_stop_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic stop_req,
  input logic slf_wake_en,
  input logic wake_msk,
  input logic busy,
  input logic bit_stb,
  input logic rx_in,
  input logic wake_clr,
  input logic stop_ack,
  input logic not_rdy,
  input logic lpm_ack,
  input logic tx_pin,
  input logic rx_core,
  input logic wake_flag,
  input logic wake_irq,
  input logic on_bus
);

  a_r2_drained: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_ack) |-> $past(!busy) && $past(stop_req));

  a_r3_muted: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ack |-> tx_pin && rx_core);

  a_r4_status: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ack |-> not_rdy && lpm_ack && !on_bus);

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ack && !stop_req) |=> !stop_ack);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ack && stop_req) |=> stop_ack);

  a_r7_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> wake_flag && slf_wake_en && wake_msk);

  a_r9_rejoin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_bus) && !$past(stop_ack) |-> ($past(bit_stb) && $past(rx_in)) || !$past(stop_req));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_flag && !wake_clr) |=> wake_flag);

endmodule

bind can_stop_ctl can_stop_ctl_chk u_chk (.*);

// File: tb/can_stop_ctl_bench.sv
module can_stop_ctl_bench;
  logic clk = 0, rst_n = 0;
  logic stop_req = 0, slf_wake_en = 0, wake_msk = 0, bus_idle = 0, bus_off = 0;
  logic intm3_smp = 0, busy = 0, bit_stb = 0, rx_in = 1, tx_core = 0, wake_clr = 0;
  logic stop_ack, not_rdy, lpm_ack, tx_pin, rx_core, wake_flag, wake_irq, on_bus;

  always #4 clk = ~clk;

  can_stop_ctl u_can_stop_ctl (.*);

  int total = 0, bad = 0, cycles = 0;
  int ms = 0, mcnt = 0;
  bit marmed = 0, mflag = 0, mrxp = 1, seen_ack = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mcnt = 0; marmed = 0; mflag = 0; mrxp = 1;
    end else begin
      if (ms == 3 && marmed && mrxp && !rx_in) mflag = 1;
      else if (wake_clr) mflag = 0;
      mrxp = rx_in;
      case (ms)
        0: if (stop_req) ms = 1;
        1: if (!stop_req) ms = 0; else if (bus_idle || bus_off || (intm3_smp && rx_in)) ms = 2;
        2: if (!stop_req) ms = 0; else if (!busy) begin ms = 3; marmed = slf_wake_en; end
        3: if (!stop_req) begin ms = 4; mcnt = 0; end
        default: if (bit_stb) begin
          if (!rx_in) mcnt = 0;
          else if (mcnt == 10) begin mcnt = 0; ms = 0; end
          else mcnt++;
        end
      endcase
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic cyc();
    bit mute;
    @(posedge clk); #2;
    cycles++;
    if (stop_ack) seen_ack = 1;
    mute = (ms == 3 || ms == 4);
    chk("R4 stop_ack", stop_ack, ms == 3);
    chk("R4 not_rdy", not_rdy, ms == 3);
    chk("R4 lpm_ack", lpm_ack, ms == 3);
    chk("R3 tx_pin", tx_pin, mute | tx_core);
    chk("R3 rx_core", rx_core, mute | rx_in);
    chk("R6 wake_flag", wake_flag, mflag);
    chk("R7 wake_irq", wake_irq, mflag & slf_wake_en & wake_msk);
    chk("R9 on_bus", on_bus, ms == 0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic resync(input int n);
    for (int i = 0; i < n; i++) begin
      bit_stb = 1; cyc(); bit_stb = 0; cyc();
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R12 on_bus", on_bus, 1); chk("R12 stop_ack", stop_ack, 0);
    chk("R12 wake_flag", wake_flag, 0); chk("R12 not_rdy", not_rdy, 0);
    rst_n = 1; run(2);

    // R1: bus active, no entry; dominant intermission sample ignored
    tx_core = 0; stop_req = 1; run(5);
    chk("R1 blocked", stop_ack, 0);
    intm3_smp = 1; rx_in = 0; cyc(); intm3_smp = 0; rx_in = 1; run(3);
    chk("R1 dominant intm3", stop_ack, 0);
    // R2: busy holds entry after intermission ok
    busy = 1; intm3_smp = 1; cyc(); intm3_smp = 0; run(4);
    chk("R2 busy holds", stop_ack, 0);
    slf_wake_en = 1; wake_msk = 1; busy = 0; run(2);
    chk("R2 entered", stop_ack, 1);
    // R6 R7: wake edge
    tx_core = 0; rx_in = 0; run(2);
    chk("R6 flag set", wake_flag, 1); chk("R7 irq", wake_irq, 1);
    chk("R3 tx forced", tx_pin, 1); chk("R3 rx gated", rx_core, 1);
    wake_msk = 0; cyc(); chk("R7 masked", wake_irq, 0);
    // R8 R9: exit and resync with a dominant interruption
    stop_req = 0; cyc(); chk("R4 ack clears", stop_ack, 0); chk("R8 still off bus", on_bus, 0);
    rx_in = 1; resync(6); rx_in = 0; resync(1); rx_in = 1; resync(10);
    chk("R9 ten not enough", on_bus, 0);
    resync(1); chk("R9 rejoined", on_bus, 1);
    // R10: sticky, then clear
    run(3); chk("R10 sticky", wake_flag, 1);
    wake_clr = 1; cyc(); wake_clr = 0; chk("R10 cleared", wake_flag, 0);
    // R11: withdraw before entry
    seen_ack = 0; stop_req = 1; run(3); stop_req = 0; run(3);
    chk("R11 no ack", seen_ack, 0); chk("R11 on bus", on_bus, 1);
    // R5: unarmed entry via bus_off, enable later
    slf_wake_en = 0; bus_off = 1; stop_req = 1; run(4); bus_off = 0;
    chk("R5 entered", stop_ack, 1);
    slf_wake_en = 1; wake_msk = 1; rx_in = 0; run(2); rx_in = 1; run(1);
    chk("R5 not armed", wake_flag, 0);
    stop_req = 0; cyc(); resync(11); chk("R9 rejoin2", on_bus, 1);
    // R10 set wins over clear, idle entry armed
    bus_idle = 1; stop_req = 1; run(4); bus_idle = 0;
    rx_in = 0; wake_clr = 1; cyc(); wake_clr = 0; rx_in = 1;
    chk("R10 set wins", wake_flag, 1);
    slf_wake_en = 0; cyc(); chk("R7 en off", wake_irq, 0);
    stop_req = 0; cyc(); resync(11); run(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule